// File: doc/BRIEF.md
# Character Cell Overlay Generator

The block draws a text overlay from a display memory of character cells. An external video timing source supplies a dot position (`hpos`) and a line position (`vpos`). For each position the block finds the character cell it falls in and reads that cell's word from the display memory. It draws the 10x10 dot pattern of the character code and produces a pixel-valid flag, a foreground-dot flag and two 4-bit colour indices. Colour selection and mixing are left to the logic that follows.

The overlay is a grid of 26 rows by 80 cells, and each cell is 10 dots square. A cell word holds either a character or a serial colour attribute. A serial attribute changes the colours used for the rest of its row. A character may carry its own parallel attributes: a colour pair from an upper bank and an underline, both for that cell only. A small per-row size table selects single or double width and single or double height. Together these give four character sizes.

The display memory and the size table each have a synchronous write port. The glyph source is a computed pattern function, not a stored font.

Top module: `osd_char_gen`

## Requirements
- R1: When `hpos` >= 800 or `vpos` >= 260, and while reset is held, `pix_valid`, `pix_dot`, `pix_fg` and `pix_bg` are all zero.
- R2: The result for a position appears on the outputs two clock cycles after that position is presented. For a position inside the area, `pix_valid` is 1.
- R3: In a single-size row the cell word is read from address row*80+col, where row = vpos/10, col = hpos/10, dot = hpos%10 and line = vpos%10. The word fields are:
  - bits 8:0: character code
  - bit 9: serial-attribute marker
  - bits 12:10: colour A
  - bits 15:13: colour B
  - bit 16: parallel enable
  - bit 17: underline
- R4: For a character cell, the dot at glyph column gx and glyph row gy is w[(9-gx-gy) mod 10], where w = {code, XOR of all code bits}. A set dot drives `pix_dot` high. With single size, gx = dot and gy = line.
- R5: A cell with bit 9 set shows no foreground dots. Its colour A becomes the foreground (0..7) and its colour B becomes the background (0..7), both for that cell and for every following cell of the row.
- R6: Each row starts with foreground 7 and background 0, whatever state the previous row ended in.
- R7: A character cell with bit 16 set shows foreground 8+A and background 8+B. This applies to that cell only and leaves the serial colours unchanged.
- R8: A character cell with bit 17 set has every dot of glyph row 9 lit.
- R9: In a double-width row, display columns 2k and 2k+1 both show cell 2k, with gx = (col odd ? 5 : 0) + dot/2. Cells at odd columns are not shown.
- R10: When an even row r has double height, row r shows gy = line/2. Row r+1 shows the cells of row r with gy = 5+line/2 and uses row r's width setting.
- R11: A double-height setting written for an odd row has no effect on any row.
- R12: After reset every row is single size. A write on the size port changes the size of the addressed row for the following scans.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hpos | input | 10 | Dot position on the line |
| vpos | input | 9 | Line position in the frame |
| wr_en | input | 1 | Display memory write strobe |
| wr_addr | input | 12 | Display memory cell address |
| wr_data | input | 18 | Cell word to write |
| size_we | input | 1 | Size table write strobe |
| size_row | input | 5 | Row whose size is written |
| size_dw | input | 1 | Double-width setting |
| size_dh | input | 1 | Double-height setting |
| pix_valid | output | 1 | Position lies inside the overlay area |
| pix_dot | output | 1 | Foreground dot |
| pix_fg | output | 4 | Foreground colour index |
| pix_bg | output | 4 | Background colour index |

## Verification
Every output is due exactly two clock cycles after its position is driven. The path is one register stage alongside the display memory read, then the output register. The scoreboard stamps each expected item with the cycle count at which the position was driven. The monitor compares an item only once two rising edges have passed since that stamp, so memory writes and idle cycles cannot shift the pairing. The expected serial colours come from rescanning the mirrored row from column 0 for every dot. For that reason the scans always sweep a line contiguously from `hpos` 0, as a real timing source does.

// File: rtl/osd_pkg.sv
package osd_pkg;

  localparam int CELL_W = 10;
  localparam int CELL_H = 10;
  localparam int CODE_W = 9;
  localparam int CLR_W  = 3;
  localparam int IDX_W  = CLR_W + 1;

  typedef struct packed {
    logic              ul;
    logic              par;
    logic [CLR_W-1:0]  clr_b;
    logic [CLR_W-1:0]  clr_a;
    logic              serial;
    logic [CODE_W-1:0] code;
  } cell_t;

  localparam int WORD_W = $bits(cell_t);

  // Dot pattern: the code with its parity appended, rotated by the glyph
  // row, read from the left.
  function automatic logic glyph_dot(input logic [CODE_W-1:0] code,
                                     input logic [3:0] gx,
                                     input logic [3:0] gy);
    logic [CELL_W-1:0]   seed;
    logic [2*CELL_W-1:0] twin;
    logic [2*CELL_W-1:0] rot;
    seed = {code, ^code};
    twin = {seed, seed};
    rot  = twin >> (5'(CELL_W) - 5'(gy));
    return rot[4'(CELL_W - 1) - gx];
  endfunction

  // Scale a coordinate: half-resolution index within a doubled span.
  function automatic logic [3:0] half_pos(input logic upper, input logic [3:0] pos,
                                          input int span);
    logic [4:0] tall;
    tall = (upper ? 5'(span) : 5'd0) + 5'(pos);
    return 4'(tall >> 1);
  endfunction

endpackage

// File: rtl/osd_row_sizes.sv
module osd_row_sizes #(
  parameter int ROWS = 26,
  localparam int RW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            size_we,
  input  logic [RW-1:0]   size_row,
  input  logic            size_dw,
  input  logic            size_dh,
  output logic [ROWS-1:0] dw_vec,
  output logic [ROWS-1:0] dh_vec
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit;
    assign hit = size_we && (size_row == RW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dw_vec[r] <= 1'b0;
        dh_vec[r] <= 1'b0;
      end else if (hit) begin
        dw_vec[r] <= size_dw;
        dh_vec[r] <= size_dh;
      end
    end
  end

endmodule

// File: rtl/osd_geom.sv
module osd_geom
  import osd_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 26,
  parameter int XW = 10,
  parameter int YW = 9,
  localparam int AW = $clog2(COLS * ROWS),
  localparam int RW = $clog2(ROWS),
  localparam int CLW = $clog2(COLS)
) (
  input  logic [XW-1:0]   hpos,
  input  logic [YW-1:0]   vpos,
  input  logic [ROWS-1:0] dw_vec,
  input  logic [ROWS-1:0] dh_vec,
  output logic            active,
  output logic            col0,
  output logic [AW-1:0]   addr,
  output logic [3:0]      gx,
  output logic [3:0]      gy
);

  logic [RW-1:0]  row, pair_row, src_row;
  logic [CLW-1:0] col, src_col;
  logic [3:0]     line, dot;
  logic           lower, upper, wide;

  always_comb begin
    active = (hpos < XW'(COLS * CELL_W)) && (vpos < YW'(ROWS * CELL_H));
    row  = active ? RW'(vpos / YW'(CELL_H)) : '0;
    col  = active ? CLW'(hpos / XW'(CELL_W)) : '0;
    line = active ? 4'(vpos % YW'(CELL_H)) : '0;
    dot  = active ? 4'(hpos % XW'(CELL_W)) : '0;

    // Double height works on row pairs: the even row owns the setting.
    pair_row = {row[RW-1:1], 1'b0};
    lower    = row[0] && dh_vec[pair_row];
    upper    = !row[0] && dh_vec[row];
    src_row  = lower ? pair_row : row;

    wide    = dw_vec[src_row];
    src_col = wide ? {col[CLW-1:1], 1'b0} : col;

    gy = (lower || upper) ? half_pos(lower, line, CELL_H) : line;
    gx = wide ? half_pos(col[0], dot, CELL_W) : dot;

    col0 = (col == '0);
    addr = AW'(int'(src_row) * COLS + int'(src_col));
  end

endmodule

// File: rtl/osd_cell_ram.sv
module osd_cell_ram #(
  parameter int DEPTH = 2080,
  parameter int W = 18,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
    rdata <= (int'(raddr) < DEPTH) ? mem[raddr] : '0;
  end

endmodule

// File: rtl/osd_attr_merge.sv
module osd_attr_merge
  import osd_pkg::*;
#(
  parameter int DEF_FG = 7,
  parameter int DEF_BG = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_active,
  input  logic             s1_col0,
  input  logic [3:0]       s1_gx,
  input  logic [3:0]       s1_gy,
  input  cell_t            s1_word,
  output logic             pix_valid,
  output logic             pix_dot,
  output logic [IDX_W-1:0] pix_fg,
  output logic [IDX_W-1:0] pix_bg
);

  logic [CLR_W-1:0] ser_fg_q, ser_bg_q;
  logic [CLR_W-1:0] base_fg, base_bg, next_fg, next_bg;
  logic [IDX_W-1:0] fg_c, bg_c;
  logic             dot_c;

  always_comb begin
    base_fg = s1_col0 ? CLR_W'(DEF_FG) : ser_fg_q;
    base_bg = s1_col0 ? CLR_W'(DEF_BG) : ser_bg_q;
    next_fg = s1_word.serial ? s1_word.clr_a : base_fg;
    next_bg = s1_word.serial ? s1_word.clr_b : base_bg;

    dot_c = !s1_word.serial &&
            (glyph_dot(s1_word.code, s1_gx, s1_gy) ||
             (s1_word.ul && (s1_gy == 4'(CELL_H - 1))));

    if (!s1_word.serial && s1_word.par) begin
      fg_c = {1'b1, s1_word.clr_a};
      bg_c = {1'b1, s1_word.clr_b};
    end else begin
      fg_c = {1'b0, next_fg};
      bg_c = {1'b0, next_bg};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_fg_q  <= CLR_W'(DEF_FG);
      ser_bg_q  <= CLR_W'(DEF_BG);
      pix_valid <= 1'b0;
      pix_dot   <= 1'b0;
      pix_fg    <= '0;
      pix_bg    <= '0;
    end else begin
      if (s1_active) begin
        ser_fg_q <= next_fg;
        ser_bg_q <= next_bg;
      end
      pix_valid <= s1_active;
      pix_dot   <= s1_active && dot_c;
      pix_fg    <= s1_active ? fg_c : '0;
      pix_bg    <= s1_active ? bg_c : '0;
    end
  end

endmodule

// File: rtl/osd_char_gen.sv
module osd_char_gen
  import osd_pkg::*;
#(
  parameter int COLS = 80,
  parameter int ROWS = 26,
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int DEF_FG = 7,
  parameter int DEF_BG = 0,
  localparam int AW = $clog2(COLS * ROWS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] hpos,
  input  logic [YW-1:0] vpos,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [17:0]   wr_data,
  input  logic          size_we,
  input  logic [RW-1:0] size_row,
  input  logic          size_dw,
  input  logic          size_dh,
  output logic          pix_valid,
  output logic          pix_dot,
  output logic [3:0]    pix_fg,
  output logic [3:0]    pix_bg
);

  logic [ROWS-1:0] dw_vec, dh_vec;
  logic            act0, col0;
  logic [AW-1:0]   rd_addr;
  logic [3:0]      gx0, gy0;
  logic            s1_active, s1_col0;
  logic [3:0]      s1_gx, s1_gy;
  logic [WORD_W-1:0] rd_word;
  cell_t           s1_word;
  logic            s1_serial, s1_par, s1_ul;

  osd_row_sizes #(.ROWS(ROWS)) u_sizes (
    .clk(clk), .rst_n(rst_n), .size_we(size_we), .size_row(size_row),
    .size_dw(size_dw), .size_dh(size_dh), .dw_vec(dw_vec), .dh_vec(dh_vec)
  );

  osd_geom #(.COLS(COLS), .ROWS(ROWS), .XW(XW), .YW(YW)) u_geom (
    .hpos(hpos), .vpos(vpos), .dw_vec(dw_vec), .dh_vec(dh_vec),
    .active(act0), .col0(col0), .addr(rd_addr), .gx(gx0), .gy(gy0)
  );

  osd_cell_ram #(.DEPTH(COLS * ROWS), .W(WORD_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(WORD_W'(wr_data)),
    .raddr(rd_addr), .rdata(rd_word)
  );

  // Position stage that travels alongside the memory read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_active <= 1'b0;
      s1_col0   <= 1'b0;
      s1_gx     <= '0;
      s1_gy     <= '0;
    end else begin
      s1_active <= act0;
      s1_col0   <= col0;
      s1_gx     <= gx0;
      s1_gy     <= gy0;
    end
  end

  assign s1_word   = cell_t'(rd_word);
  assign s1_serial = s1_word.serial;
  assign s1_par    = s1_word.par;
  assign s1_ul     = s1_word.ul;

  osd_attr_merge #(.DEF_FG(DEF_FG), .DEF_BG(DEF_BG)) u_merge (
    .clk(clk), .rst_n(rst_n), .s1_active(s1_active), .s1_col0(s1_col0),
    .s1_gx(s1_gx), .s1_gy(s1_gy), .s1_word(s1_word),
    .pix_valid(pix_valid), .pix_dot(pix_dot), .pix_fg(pix_fg), .pix_bg(pix_bg)
  );

endmodule

// File: rtl/osd_char_gen_chk.sv
module osd_char_gen_chk #(
  parameter int DEF_FG = 7,
  parameter int DEF_BG = 0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       act0,
  input logic       s1_active,
  input logic       s1_col0,
  input logic       s1_serial,
  input logic       s1_par,
  input logic       s1_ul,
  input logic [3:0] s1_gy,
  input logic       pix_valid,
  input logic       pix_dot,
  input logic [3:0] pix_fg,
  input logic [3:0] pix_bg
);

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (!pix_dot && pix_fg == 4'd0 && pix_bg == 4'd0)); // R1

  AST_DARK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !act0 |=> ##1 !pix_valid); // R1

  AST_TWO_CYCLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    act0 |=> ##1 pix_valid); // R2

  AST_ATTR_CELL_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_active && s1_serial) |=> !pix_dot); // R5

  AST_ROW_START_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_active && s1_col0 && !s1_serial && !s1_par)
      |=> (pix_fg == 4'(DEF_FG) && pix_bg == 4'(DEF_BG))); // R6

  AST_PAR_UPPER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_active && !s1_serial && s1_par) |=> (pix_fg[3] && pix_bg[3])); // R7

  AST_UNDERLINE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_active && !s1_serial && s1_ul && s1_gy == 4'd9) |=> pix_dot); // R8

endmodule

bind osd_char_gen osd_char_gen_chk #(.DEF_FG(DEF_FG), .DEF_BG(DEF_BG)) u_chk (
  .clk(clk), .rst_n(rst_n), .act0(act0), .s1_active(s1_active),
  .s1_col0(s1_col0), .s1_serial(s1_serial), .s1_par(s1_par), .s1_ul(s1_ul),
  .s1_gy(s1_gy), .pix_valid(pix_valid), .pix_dot(pix_dot),
  .pix_fg(pix_fg), .pix_bg(pix_bg)
);

// File: tb/osd_char_gen_test.sv
module osd_char_gen_test;
  localparam int CLK_P = 10;
  localparam int NC = 80;
  localparam int NR = 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  hpos = 10'd1023;
  logic [8:0]  vpos = 9'd0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic        size_we = 1'b0;
  logic [4:0]  size_row = '0;
  logic        size_dw = 1'b0;
  logic        size_dh = 1'b0;
  logic        pix_valid, pix_dot;
  logic [3:0]  pix_fg, pix_bg;

  always #(CLK_P / 2) clk = ~clk;

  osd_char_gen uut (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .size_we(size_we),
    .size_row(size_row), .size_dw(size_dw), .size_dh(size_dh),
    .pix_valid(pix_valid), .pix_dot(pix_dot), .pix_fg(pix_fg), .pix_bg(pix_bg)
  );

  typedef struct {
    int         t;
    int         x;
    int         y;
    logic       v;
    logic       d;
    logic [3:0] fg;
    logic [3:0] bg;
    string      tag;
  } exp_t;

  exp_t        sb[$];
  logic [17:0] mirror [NR * NC];
  bit          dw_t [NR];
  bit          dh_t [NR];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc++;

  // Monitor: each item is due two rising edges after its stamp.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].t + 2 <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (pix_valid !== e.v || pix_dot !== e.d || pix_fg !== e.fg || pix_bg !== e.bg) begin
        errors++;
        $display("FAIL %s x=%0d y=%0d actual v=%0b d=%0b fg=%0d bg=%0d expected v=%0b d=%0b fg=%0d bg=%0d",
                 e.tag, e.x, e.y, pix_valid, pix_dot, pix_fg, pix_bg, e.v, e.d, e.fg, e.bg);
      end
    end
  end

  function automatic logic [17:0] mk(int code, bit ser, int a, int b, bit par, bit ul);
    return {ul, par, 3'(b), 3'(a), ser, 9'(code)};
  endfunction

  function automatic void model(input int x, input int y, output logic v, output logic d,
                                output logic [3:0] fg, output logic [3:0] bg);
    int row, ln, col, dt, srow, scol, gx, gy, k, fs, bs;
    bit lower, top, wide, bitv;
    logic [17:0] cur, w;
    v = 0; d = 0; fg = 0; bg = 0;
    if (x >= NC * 10 || y >= NR * 10) return;
    v = 1;
    row = y / 10; ln = y % 10; col = x / 10; dt = x % 10;
    lower = (row % 2 == 1) && dh_t[row - 1];
    top   = (row % 2 == 0) && dh_t[row];
    srow  = lower ? row - 1 : row;
    gy    = top ? ln / 2 : (lower ? 5 + ln / 2 : ln);
    wide  = dw_t[srow];
    scol  = wide ? col - col % 2 : col;
    gx    = wide ? (col % 2) * 5 + dt / 2 : dt;
    fs = 7; bs = 0;
    for (int j = 0; j <= col; j++) begin
      w = mirror[srow * NC + (wide ? j - j % 2 : j)];
      if (w[9]) begin fs = int'(w[12:10]); bs = int'(w[15:13]); end
    end
    cur = mirror[srow * NC + scol];
    if (cur[9]) begin
      d = 0; fg = 4'(fs); bg = 4'(bs);
    end else begin
      k = ((9 - gx - gy) % 10 + 20) % 10;
      bitv = (k == 0) ? ^cur[8:0] : cur[k - 1];
      d = bitv || (cur[17] && gy == 9);
      if (cur[16]) begin
        fg = 4'(8 + int'(cur[12:10])); bg = 4'(8 + int'(cur[15:13]));
      end else begin
        fg = 4'(fs); bg = 4'(bs);
      end
    end
  endfunction

  task automatic put_cell(int r, int c, logic [17:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 12'(r * NC + c); wr_data = w;
    mirror[r * NC + c] = w;
  endtask

  task automatic wr_idle();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_size(int r, bit w, bit h);
    @(negedge clk);
    size_we = 1'b1; size_row = 5'(r); size_dw = w; size_dh = h;
    dw_t[r] = w; dh_t[r] = h;
    @(negedge clk);
    size_we = 1'b0;
  endtask

  // Driver: sweeps one line from dot 0 and queues the expected results.
  task automatic scan(int y, string tag);
    for (int x = 0; x < 820; x++) begin
      exp_t e;
      @(negedge clk);
      hpos = 10'(x); vpos = 9'(y);
      e.t = cyc; e.x = x; e.y = y; e.tag = tag;
      model(x, y, e.v, e.d, e.fg, e.bg);
      sb.push_back(e);
    end
    @(negedge clk);
    hpos = 10'd1023;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) begin dw_t[i] = 0; dh_t[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state of the outputs
    checks++;
    if (pix_valid !== 1'b0 || pix_dot !== 1'b0 || pix_fg !== 4'd0 || pix_bg !== 4'd0) begin
      errors++;
      $display("FAIL R1 reset actual v=%0b d=%0b fg=%0d bg=%0d expected all zero",
               pix_valid, pix_dot, pix_fg, pix_bg);
    end
    rst_n = 1'b1;
    for (int i = 0; i < NR * NC; i++) put_cell(i / NC, i % NC, 18'd0);

    // Row 0: plain glyphs, serial colours, parallel colours, underline
    put_cell(0, 0, mk(9'h1A5, 0, 0, 0, 0, 0));
    put_cell(0, 1, mk(0, 1, 3, 5, 0, 0));
    put_cell(0, 2, mk(9'h0F3, 0, 0, 0, 0, 0));
    put_cell(0, 3, mk(9'h155, 0, 2, 6, 1, 0));
    put_cell(0, 4, mk(9'h0AA, 0, 0, 0, 0, 1));
    put_cell(0, 5, mk(0, 0, 0, 0, 0, 1));
    put_cell(0, 40, mk(0, 1, 6, 2, 0, 0));
    put_cell(0, 79, mk(9'h1FF, 0, 0, 0, 0, 0));
    // Row 1: starts after a row that ended in non-default colours
    put_cell(1, 0, mk(9'h123, 0, 0, 0, 0, 0));
    put_cell(1, 1, mk(9'h0B7, 0, 0, 0, 0, 0));
    put_cell(1, 9, mk(0, 1, 1, 2, 0, 0));
    // Row 2: double width
    put_cell(2, 0, mk(9'h0C3, 0, 0, 0, 0, 0));
    put_cell(2, 1, mk(9'h1FF, 0, 0, 0, 0, 0));
    put_cell(2, 2, mk(0, 1, 4, 1, 0, 0));
    put_cell(2, 3, mk(0, 1, 5, 5, 0, 0));
    put_cell(2, 4, mk(9'h06D, 0, 0, 0, 0, 0));
    // Rows 4/5: double height pair
    put_cell(4, 0, mk(9'h137, 0, 0, 0, 0, 0));
    put_cell(4, 1, mk(9'h05A, 0, 0, 0, 0, 1));
    put_cell(5, 0, mk(9'h1FF, 0, 0, 0, 0, 0));
    // Rows 6/7: height setting on the odd row
    put_cell(6, 0, mk(9'h08F, 0, 0, 0, 0, 0));
    put_cell(7, 0, mk(9'h0E1, 0, 0, 0, 0, 0));
    // Rows 10/11: double width and height
    put_cell(10, 0, mk(9'h1C9, 0, 3, 4, 1, 1));
    put_cell(10, 2, mk(9'h0F0, 0, 0, 0, 0, 0));
    put_cell(11, 0, mk(9'h03C, 0, 0, 0, 0, 0));
    put_cell(25, 79, mk(9'h111, 0, 0, 0, 0, 1));
    wr_idle();

    set_size(2, 1, 0);
    set_size(4, 0, 1);
    set_size(7, 0, 1);
    set_size(10, 1, 1);

    scan(0, "R2");      // valid timing, glyphs, inactive tail
    scan(5, "R3");      // cell addressing, serial and parallel cells
    scan(7, "R4");      // glyph pattern rows
    scan(9, "R8");      // underline row
    scan(3, "R5");
    scan(6, "R7");
    scan(10, "R6");     // row start defaults after a coloured row
    scan(16, "R6");
    scan(22, "R9");
    scan(41, "R10");
    scan(57, "R10");
    scan(73, "R11");
    scan(66, "R11");
    scan(104, "R12");
    scan(118, "R12");
    set_size(10, 0, 0); // R12: size rewrite takes effect
    scan(118, "R12");
    scan(259, "R4");
    scan(260, "R1");
    scan(300, "R1");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule